// File: doc/BRIEF.md
# Binary-Tree Serial-to-Parallel Converter

This block collects a serial bit stream into parallel words of 2^N bits. Rather than shifting bits through a single register, it passes them down a tree of ping-pong 1:2 splitters. The first level sorts bits by the lowest bit of their position in the word. Each later level takes the pairs, quads and so on from the level above and sorts them again, at half the rate of the level before. A level with index i holds 2^i splitter cells. Cell j of a level with B cells places its first capture on line j and its second on line j+B. After the last level, a bit's line number is its arrival position in the word.

Everything runs from the one full-rate clock. An N-bit phase counter stands in for a chain of divide-by-2 stages: counter bit i acts as the halved clock that paces level i, and the top bit is driven out as a slow clock. Each level can be given an optional aligning register pair, so that both halves of its output change on the same edge. An endian option mirrors the finished word. Each completed word is shown with a one-cycle valid pulse, and the word is held until the next one completes.

Top module: `deser_tree`

## Requirements
- R1: The output word is 2^NUM_STAGES bits wide, with NUM_STAGES from 1 to 5. While reset is applied, `word_out`, `word_valid` and `slow_clk` are all 0.
- R2: With BIG_ENDIAN = 0, the bit sampled at enabled position k (k = 0 for the first bit after reset or after the previous word) appears on `word_out[k]`.
- R3: With BIG_ENDIAN = 1, that same bit appears on `word_out[2^NUM_STAGES-1-k]`.
- R4: `word_valid` goes high for exactly one cycle for each group of 2^NUM_STAGES enabled samples. Between pulses, `word_out` holds its value.
- R5: If the last bit of a word is sampled at clock edge E, the word and its valid pulse are presented right after edge E + NUM_STAGES + R, where R is the number of levels with an aligning register.
- R6: While `en` is low, `ser_in` is ignored and the phase counter holds. Bits offered while `en` is low never appear in any word.
- R7: `slow_clk` equals bit NUM_STAGES-1 of the count of enabled samples modulo 2^NUM_STAGES. It is low for the first half of each word and high for the second half.
- R8: A synchronous active-high reset discards any partly collected word. The first word after reset holds the first 2^NUM_STAGES enabled samples taken after reset is released.
- R9: RETIME_ALL = 1, or a set bit i in RETIME_MASK, adds an aligning register pair to level i. This changes only the latency, never the word contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate bit clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample enable; when low, the phase counter holds |
| ser_in | input | 1 | Serial data, sampled on enabled edges |
| word_out | output | 2^NUM_STAGES | Parallel word, held between valid pulses |
| word_valid | output | 1 | One-cycle pulse when a new word is shown |
| slow_clk | output | 1 | Top bit of the phase counter (divided clock) |

## Verification
Two instances are driven from the same stream: one with three levels, little-endian output and a single aligned level, and one with two levels, big-endian output and every level aligned. A walking single one shows whether each arrival position lands on the right line in both bit orders. Alternating, all-ones and all-zeros words show whether neighbouring lines or levels have been swapped or stuck. A long pseudo-random stream with irregular enable gaps, and random data offered while the enable is low, separates correct framing and hold behaviour from counting raw clock cycles. A reset in the middle of a word checks that the partial word is dropped. Each word is also checked for arriving on its exact cycle, which catches a missing or extra register in any level.

// File: rtl/deser_pkg.sv
package deser_pkg;

    // Largest supported tree depth; the index tag is sized for it.
    localparam int MAX_STAGES = 5;

    // Arrival position of the bit that completed a group.
    typedef logic [MAX_STAGES-1:0] tag_t;

    // Strobe travelling down the tree beside the data.
    typedef struct packed {
        logic stb;
        tag_t tag;
    } link_ctl_t;

    // Output line for arrival position k in the selected bit order.
    function automatic int out_index(input int k, input int width, input bit big);
        return big ? (width - 1 - k) : k;
    endfunction

    // Word width for a given depth.
    function automatic int word_width(input int stages);
        return 1 << stages;
    endfunction

endpackage

// File: rtl/deser_divider.sv
module deser_divider #(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [STAGES-1:0] phase,
    output logic              slow_clk
);

    logic [STAGES-1:0] phase_q;

    // Bit i of this counter toggles at the rate of the i-th halving stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (en) begin
            phase_q <= phase_q + STAGES'(1);
        end
    end

    assign phase    = phase_q;
    assign slow_clk = phase_q[STAGES-1];

    // R6: without enable the phase does not move
    a_r6_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(phase_q));

    // R7: divided clock only changes on enabled edges
    a_r7_slow_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(slow_clk));

    // R4: the count wraps to zero after a full word
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (en && (phase_q == '1)) |=> (phase_q == '0));

endmodule

// File: rtl/deser_stage.sv
module deser_stage
    import deser_pkg::*;
#(
    parameter int IDX    = 0,
    parameter bit RETIME = 1'b0,
    localparam int CELLS = 1 << IDX,
    localparam int OW    = 2 * CELLS
) (
    input  logic             clk,
    input  logic             rst,
    input  link_ctl_t        in_ctl,
    input  logic [CELLS-1:0] din,
    output link_ctl_t        out_ctl,
    output logic [OW-1:0]    dout
);

    logic [OW-1:0] raw;
    link_ctl_t     done_q;

    // One ping-pong splitter per cell: the group's index bit IDX picks the half.
    for (genvar j = 0; j < CELLS; j++) begin : g_cell
        logic lo_r;
        logic hi_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                lo_r <= 1'b0;
                hi_r <= 1'b0;
            end else if (in_ctl.stb) begin
                if (in_ctl.tag[IDX]) begin
                    hi_r <= din[j];
                end else begin
                    lo_r <= din[j];
                end
            end
        end

        assign raw[j]         = lo_r;
        assign raw[j + CELLS] = hi_r;
    end

    // A group for the next level is complete once the high half is written.
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= '0;
        end else begin
            done_q <= '{stb: in_ctl.stb & in_ctl.tag[IDX], tag: in_ctl.tag};
        end
    end

    if (RETIME) begin : g_rt
        logic [OW-1:0] al_q;
        link_ctl_t     ctl_q;

        // Both halves move together, one cycle after the group completes.
        always_ff @(posedge clk) begin
            if (rst) begin
                al_q  <= '0;
                ctl_q <= '0;
            end else begin
                ctl_q <= done_q;
                if (done_q.stb) begin
                    al_q <= raw;
                end
            end
        end

        assign dout    = al_q;
        assign out_ctl = ctl_q;

        // R9: aligned outputs only change on a completed group
        a_r9_aligned_hold: assert property (@(posedge clk) disable iff (rst)
            !done_q.stb |=> $stable(al_q));
    end else begin : g_direct
        assign dout    = raw;
        assign out_ctl = done_q;
    end

    // R4: a level never completes two groups on consecutive cycles
    a_r4_stage_once: assert property (@(posedge clk) disable iff (rst)
        out_ctl.stb |=> !out_ctl.stb);

endmodule

// File: rtl/deser_outreg.sv
module deser_outreg
    import deser_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter bit BIG   = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] pword,
    output logic             pvalid
);

    logic [WIDTH-1:0] ordered;
    logic [WIDTH-1:0] word_q;
    logic             valid_q;

    // Place each arrival position on its output line.
    for (genvar k = 0; k < WIDTH; k++) begin : g_map
        localparam int DST = out_index(k, WIDTH, BIG);
        assign ordered[DST] = word[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
            if (load) begin
                word_q <= ordered;
            end
        end
    end

    assign pword  = word_q;
    assign pvalid = valid_q;

    // R4: the valid flag is a single-cycle pulse
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R4: the presented word is held between pulses
    a_r4_word_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> $stable(word_q));

endmodule

// File: rtl/deser_tree.sv
module deser_tree
    import deser_pkg::*;
#(
    parameter int                    NUM_STAGES  = 3,
    parameter bit                    BIG_ENDIAN  = 1'b0,
    parameter bit                    RETIME_ALL  = 1'b0,
    parameter logic [NUM_STAGES-1:0] RETIME_MASK = '0,
    localparam int                   WIDTH       = 1 << NUM_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ser_in,
    output logic [WIDTH-1:0] word_out,
    output logic             word_valid,
    output logic             slow_clk
);

    localparam logic [NUM_STAGES-1:0] RT_EFF = RETIME_ALL ? '1 : RETIME_MASK;

    if (NUM_STAGES < 1 || NUM_STAGES > MAX_STAGES) begin : g_bad_depth
        $error("deser_tree: NUM_STAGES out of range");
    end

    logic [NUM_STAGES-1:0] phase;
    link_ctl_t             head_ctl;
    link_ctl_t             last_ctl;
    logic [WIDTH-1:0]      tree_word;

    deser_divider #(.STAGES(NUM_STAGES)) u_div (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .phase    (phase),
        .slow_clk (slow_clk)
    );

    assign head_ctl = '{stb: en, tag: tag_t'(phase)};

    // Level i has 2^i cells and feeds 2^(i+1) lines to level i+1.
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stg
        logic [(2 << i)-1:0] sd;
        link_ctl_t           sc;

        if (i == 0) begin : g_head
            deser_stage #(.IDX(0), .RETIME(RT_EFF[0])) u_stage (
                .clk     (clk),
                .rst     (rst),
                .in_ctl  (head_ctl),
                .din     (ser_in),
                .out_ctl (sc),
                .dout    (sd)
            );
        end else begin : g_body
            deser_stage #(.IDX(i), .RETIME(RT_EFF[i])) u_stage (
                .clk     (clk),
                .rst     (rst),
                .in_ctl  (g_stg[i-1].sc),
                .din     (g_stg[i-1].sd),
                .out_ctl (sc),
                .dout    (sd)
            );
        end
    end

    assign tree_word = g_stg[NUM_STAGES-1].sd;
    assign last_ctl  = g_stg[NUM_STAGES-1].sc;

    deser_outreg #(.WIDTH(WIDTH), .BIG(BIG_ENDIAN)) u_out (
        .clk    (clk),
        .rst    (rst),
        .load   (last_ctl.stb),
        .word   (tree_word),
        .pword  (word_out),
        .pvalid (word_valid)
    );

    // R4: the last level fires only on the final bit position of a word
    a_r4_word_end: assert property (@(posedge clk) disable iff (rst)
        last_ctl.stb |-> (last_ctl.tag == tag_t'(WIDTH - 1)));

    // R8: no stale word escapes right after reset
    a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!word_valid && (word_out == '0)));

endmodule

// File: tb/deser_tree_test.sv
module deser_tree_test;

    localparam int NA = 3;
    localparam int WA = 8;
    localparam int LAT_A = 4;  // 3 levels + 1 aligned level
    localparam int NB = 2;
    localparam int WB = 4;
    localparam int LAT_B = 4;  // 2 levels + 2 aligned levels

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic sdin = 1'b0;

    logic [WA-1:0] wa;
    logic          va;
    logic          sa;
    logic [WB-1:0] wb;
    logic          vb;
    logic          sb;

    always #5 clk = ~clk;

    deser_tree #(.NUM_STAGES(NA), .BIG_ENDIAN(1'b0), .RETIME_ALL(1'b0),
                 .RETIME_MASK(3'b010)) uut (
        .clk(clk), .rst(rst), .en(en), .ser_in(sdin),
        .word_out(wa), .word_valid(va), .slow_clk(sa));

    deser_tree #(.NUM_STAGES(NB), .BIG_ENDIAN(1'b1), .RETIME_ALL(1'b1),
                 .RETIME_MASK(2'b00)) uut_be (
        .clk(clk), .rst(rst), .en(en), .ser_in(sdin),
        .word_out(wb), .word_valid(vb), .slow_clk(sb));

    typedef struct {
        logic [7:0] w;
        int         due;
    } exp_t;

    exp_t qa[$];
    exp_t qb[$];

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    int taken = 0;
    logic rst_q = 1'b0;

    logic [WA-1:0] acc_a = '0;
    logic [WB-1:0] acc_b = '0;
    int na = 0;
    int nb = 0;
    logic [WA-1:0] last_a = '0;
    logic [WB-1:0] last_b = '0;
    logic [15:0] lf = 16'hACE1;

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        rst_q <= rst;
        if (rst) taken <= 0;
        else if (en) taken <= taken + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: applies one bit and pushes finished words into the scoreboard.
    task automatic put_bit(input logic b, input logic e);
        exp_t item;
        @(posedge clk);
        #1;
        sdin = b;
        en   = e;
        if (e) begin
            acc_a[na] = b;           // R2: position k -> line k
            acc_b[WB-1-nb] = b;      // R3: position k -> line W-1-k
            na++;
            nb++;
            if (na == WA) begin
                item.w   = 8'(acc_a);
                item.due = cyc + 1 + LAT_A;  // R5
                qa.push_back(item);
                na = 0;
            end
            if (nb == WB) begin
                item.w   = 8'(acc_b);
                item.due = cyc + 1 + LAT_B;  // R5
                qb.push_back(item);
                nb = 0;
            end
        end
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        en  = 1'b0;
        qa.delete();
        qb.delete();
        na = 0;
        nb = 0;
        last_a = '0;
        last_b = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    function automatic logic lf_next();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    // Monitor: pops expected words and compares value and timing.
    always @(negedge clk) begin
        exp_t item;
        if (rst && rst_q) begin
            chk("R1 reset word A", 32'(wa), 32'h0);
            chk("R1 reset valid A", 32'(va), 32'h0);
            chk("R1 reset slow clock A", 32'(sa), 32'h0);
            chk("R1 reset valid B", 32'(vb), 32'h0);
        end else if (!rst) begin
            chk("R7 slow clock A", 32'(sa), 32'(((taken % WA) >> (NA - 1)) & 1));
            chk("R7 slow clock B", 32'(sb), 32'(((taken % WB) >> (NB - 1)) & 1));
            if (va) begin
                if (qa.size() == 0) begin
                    chk("R4 unexpected valid A", 32'(1), 32'(0));
                end else begin
                    item = qa.pop_front();
                    chk("R2 word A", 32'(wa), 32'(item.w));
                    chk("R5 latency A", 32'(cyc), 32'(item.due));
                    last_a = wa;
                end
            end else begin
                chk("R4 hold A", 32'(wa), 32'(last_a));
            end
            if (vb) begin
                if (qb.size() == 0) begin
                    chk("R4 unexpected valid B", 32'(1), 32'(0));
                end else begin
                    item = qb.pop_front();
                    chk("R3 word B", 32'(wb), 32'(item.w));
                    chk("R9 latency B", 32'(cyc), 32'(item.due));
                    last_b = wb;
                end
            end else begin
                chk("R4 hold B", 32'(wb), 32'(last_b));
            end
        end
    end

    initial begin
        repeat (30000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R2 R3: walking one across every position
        for (int p = 0; p < WA; p++) begin
            for (int k = 0; k < WA; k++) put_bit(k == p, 1'b1);
        end
        // alternating, all ones, all zeros
        for (int k = 0; k < 16; k++) put_bit(k[0], 1'b1);
        for (int k = 0; k < 16; k++) put_bit(1'b1, 1'b1);
        for (int k = 0; k < 8; k++) put_bit(1'b0, 1'b1);

        // R6: long idle with toggling data that must be ignored
        for (int k = 0; k < 20; k++) put_bit(k[0], 1'b0);

        // R6 R9: random data with irregular enable gaps
        for (int k = 0; k < 400; k++) begin
            logic d;
            logic e;
            d = lf_next();
            e = lf_next() | lf_next();
            put_bit(d, e);
        end

        // R8: reset in the middle of a word
        for (int k = 0; k < 5; k++) put_bit(1'b1, 1'b1);
        do_reset();
        for (int k = 0; k < 24; k++) put_bit(lf_next(), 1'b1);

        for (int k = 0; k < 12; k++) put_bit(1'b0, 1'b0);
        chk("R4 all words seen A", 32'(qa.size()), 32'h0);
        chk("R4 all words seen B", 32'(qb.size()), 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule